// File: doc/BRIEF.md
# Serial Line-Sensor Capture Controller

This controller runs a line-scan image sensor over a three-wire serial link. It drives a serial clock and a data line into the sensor, and it receives a data line back from the sensor. The serial clock comes from a programmable divider of the system clock. After reset the controller stays quiet for a programmable settling time. It then plays a configuration script to the sensor. The script is read word by word from an on-chip instruction memory, which has an asynchronous read port.

Once the script has been sent, the controller keeps the serial clock running and watches for the sensor to signal the start of a line. It then deserializes eight bits per pixel and writes each byte into an on-chip pixel buffer through a simple write port. When a whole line of pixels has been written, a one-cycle done pulse tells a downstream mover that the buffer holds a complete line. The controller then goes back to waiting for the next line. Line after line is captured this way, with no further script playback until the next reset.

Top module: `line_sensor_ctrl`

## Requirements
- R1: While reset is asserted, `sclk`, `sdout`, `pix_we` and `line_done` are low and `instr_addr` is 0. After reset is released, `sclk` stays low for at least `STARTUP_CYCLES` system cycles before its first rising edge.
- R2: While the serial clock runs, every level of `sclk` lasts exactly `SCK_HALF` system cycles, so the period is 2*`SCK_HALF` cycles.
- R3: `sdout` changes only while `sclk` is low, which means on a falling edge or while the clock is idle. It never changes while `sclk` is high.
- R4: Script words are 16 bits wide. They are sent starting from instruction address 0 and counting upward. Each word goes out MSB first, one bit per `sclk` rising edge, so the sensor samples 16 bits per word.
- R5: A word equal to 16'hFFFF ends the script and is not transmitted. If no such word appears, the script ends after `INSTR_DEPTH` words.
- R6: `sdout` is low whenever no script word is being transmitted.
- R7: After the script, the controller waits for a start bit, which is `sdin` sampled high at an `sclk` rising edge. No pixel write happens before that start bit, and any `sdin` activity during script transmission is ignored.
- R8: The 8 `sdin` bits that follow the start bit, sampled on rising edges, form one pixel, MSB first. Pixels follow one another with no gap. Each pixel is written with a one-cycle `pix_we` pulse. `pix_addr` equals the pixel's index within the line and restarts at 0 on every line.
- R9: After `PIXELS_PER_LINE` pixels, `line_done` pulses in the same cycle as the final write, and the controller returns to waiting. A start bit on the very next rising edge begins a new line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | output | 1 | Serial clock to the sensor |
| sdout | output | 1 | Serial data to the sensor |
| sdin | input | 1 | Serial data from the sensor |
| instr_addr | output | $clog2(INSTR_DEPTH) | Instruction memory read address |
| instr_word | input | 16 | Instruction memory read data (combinational read) |
| pix_addr | output | $clog2(PIXELS_PER_LINE) | Pixel buffer write address |
| pix_data | output | 8 | Pixel buffer write data |
| pix_we | output | 1 | Pixel buffer write enable |
| line_done | output | 1 | One-cycle pulse when a line is complete |

## Verification
The final pixel write of a line and the `line_done` pulse must appear in the same cycle. On the next serial edges, a new start bit may arrive while the controller is only just re-arming. To provoke this, the bench sends some lines with zero idle bits between them, so the next start bit follows the last pixel bit on the very next rising edge. Other lines get random gaps, and pixel values are random or directed. Every write is judged against a bench-side model that tracks the expected index and byte. The model requires `line_done` to be high exactly on the write of index `PIXELS_PER_LINE`-1, and it requires the following line to restart at address 0 with its first byte intact.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
    localparam int WORD_W = 16;
    localparam int PIX_W  = 8;

    typedef enum logic [2:0] {
        ST_BOOT    = 3'd0,
        ST_FETCH   = 3'd1,
        ST_SHIFT   = 3'd2,
        ST_WAIT    = 3'd3,
        ST_CAPTURE = 3'd4
    } lsc_state_e;
endpackage

// File: rtl/lsc_sclk_gen.sv
module lsc_sclk_gen #(
    parameter int HALF = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic sck,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sck;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d    = q;
        rise = 1'b0;
        fall = 1'b0;
        if (!en) begin
            d.cnt = '0;
            d.sck = 1'b0;
        end else if (q.cnt == LAST) begin
            d.cnt = '0;
            d.sck = ~q.sck;
            rise  = ~q.sck;
            fall  = q.sck;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck = q.sck;

    // R2: the clock only rises while enabled
    p_rise_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.sck) |-> $past(en));
    // R2: a running clock toggles only at the end of a full half period
    p_half_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && (q.sck != $past(q.sck))) |-> ($past(q.cnt) == LAST));
endmodule

// File: rtl/lsc_ser_tx.sv
module lsc_ser_tx #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] word,
    input  logic         fall,
    output logic         sdo,
    output logic         done
);
    localparam int BW = $clog2(W);
    localparam logic [BW-1:0] LAST = BW'(W - 1);

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [BW-1:0] cnt;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (load) begin
            d.sh  = word;
            d.cnt = '0;
        end else if (fall) begin
            d.sh  = {q.sh[W-2:0], 1'b0};
            d.cnt = q.cnt + 1'b1;
            done  = (q.cnt == LAST);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdo = q.sh[W-1];

    // R6: a finished word leaves the line low
    p_empty_after_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !sdo);
endmodule

// File: rtl/lsc_deser_rx.sv
module lsc_deser_rx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         sample,
    input  logic         bit_in,
    output logic [W-1:0] byte_out,
    output logic         byte_vld
);
    localparam int BW = $clog2(W);
    localparam logic [BW-1:0] LAST = BW'(W - 1);

    typedef struct packed {
        logic [W-2:0]  sh;
        logic [BW-1:0] cnt;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d        = q;
        byte_vld = 1'b0;
        byte_out = {q.sh, bit_in};
        if (clear) begin
            d = '0;
        end else if (sample) begin
            if (q.cnt == LAST) begin
                byte_vld = 1'b1;
                d.cnt    = '0;
            end else begin
                d.sh  = {q.sh[W-3:0], bit_in};
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8: a byte completes only on a sampling edge
    p_vld_on_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> sample);
endmodule

// File: rtl/line_sensor_ctrl.sv
module line_sensor_ctrl
    import lsc_pkg::*;
#(
    parameter int SCK_HALF        = 5,
    parameter int STARTUP_CYCLES  = 1000,
    parameter int INSTR_DEPTH     = 32,
    parameter int PIXELS_PER_LINE = 1024
) (
    input  logic                               clk,
    input  logic                               rst_n,
    output logic                               sclk,
    output logic                               sdout,
    input  logic                               sdin,
    output logic [$clog2(INSTR_DEPTH)-1:0]     instr_addr,
    input  logic [15:0]                        instr_word,
    output logic [$clog2(PIXELS_PER_LINE)-1:0] pix_addr,
    output logic [7:0]                         pix_data,
    output logic                               pix_we,
    output logic                               line_done
);
    localparam int IAW = $clog2(INSTR_DEPTH);
    localparam int ICW = IAW + 1;
    localparam int PAW = $clog2(PIXELS_PER_LINE);
    localparam int SUW = $clog2(STARTUP_CYCLES + 1);
    localparam logic [SUW-1:0] BOOT_LAST = SUW'(STARTUP_CYCLES - 1);
    localparam logic [ICW-1:0] DEPTH_C   = ICW'(INSTR_DEPTH);
    localparam logic [PAW-1:0] PIX_LAST  = PAW'(PIXELS_PER_LINE - 1);
    localparam logic [WORD_W-1:0] END_WORD = '1;

    typedef struct packed {
        lsc_state_e       state;
        logic [SUW-1:0]   boot_cnt;
        logic [ICW-1:0]   idx;
        logic [PAW-1:0]   pix_cnt;
        logic             wr_we;
        logic [PAW-1:0]   wr_addr;
        logic [PIX_W-1:0] wr_data;
        logic             done;
    } regs_t;

    regs_t q, d;

    logic             clk_en, sck_rise, sck_fall;
    logic             tx_load, tx_done;
    logic             rx_clear, rx_sample, rx_vld;
    logic [PIX_W-1:0] rx_byte;

    lsc_sclk_gen #(.HALF(SCK_HALF)) u_sclk (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (clk_en),
        .sck  (sclk),
        .rise (sck_rise),
        .fall (sck_fall)
    );

    lsc_ser_tx #(.W(WORD_W)) u_tx (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tx_load),
        .word (instr_word),
        .fall (sck_fall),
        .sdo  (sdout),
        .done (tx_done)
    );

    assign rx_sample = sck_rise && (q.state == ST_CAPTURE);

    lsc_deser_rx #(.W(PIX_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (rx_clear),
        .sample  (rx_sample),
        .bit_in  (sdin),
        .byte_out(rx_byte),
        .byte_vld(rx_vld)
    );

    always_comb begin
        d        = q;
        d.wr_we  = 1'b0;
        d.done   = 1'b0;
        clk_en   = 1'b0;
        tx_load  = 1'b0;
        rx_clear = 1'b0;
        case (q.state)
            ST_BOOT: begin
                if (q.boot_cnt == BOOT_LAST) d.state = ST_FETCH;
                else                         d.boot_cnt = q.boot_cnt + 1'b1;
            end
            ST_FETCH: begin
                if ((q.idx == DEPTH_C) || (instr_word == END_WORD)) begin
                    d.state = ST_WAIT;
                end else begin
                    tx_load = 1'b1;
                    d.state = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                clk_en = 1'b1;
                if (tx_done) begin
                    d.idx   = q.idx + 1'b1;
                    d.state = ST_FETCH;
                end
            end
            ST_WAIT: begin
                clk_en   = 1'b1;
                rx_clear = 1'b1;
                if (sck_rise && sdin) begin
                    d.state   = ST_CAPTURE;
                    d.pix_cnt = '0;
                end
            end
            ST_CAPTURE: begin
                clk_en = 1'b1;
                if (rx_vld) begin
                    d.wr_we   = 1'b1;
                    d.wr_addr = q.pix_cnt;
                    d.wr_data = rx_byte;
                    if (q.pix_cnt == PIX_LAST) begin
                        d.done  = 1'b1;
                        d.state = ST_WAIT;
                    end else begin
                        d.pix_cnt = q.pix_cnt + 1'b1;
                    end
                end
            end
            default: d.state = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= regs_t'('0);
        else        q <= d;
    end

    assign instr_addr = q.idx[IAW-1:0];
    assign pix_addr   = q.wr_addr;
    assign pix_data   = q.wr_data;
    assign pix_we     = q.wr_we;
    assign line_done  = q.done;

    // R1: serial clock idle through startup and fetch
    p_boot_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state inside {ST_BOOT, ST_FETCH}) |-> !sclk);
    // R3: data to the sensor is frozen while the clock is high
    p_sdo_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(sdout));
    // R5: never shift beyond the instruction memory
    p_script_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SHIFT) |-> (q.idx < DEPTH_C));
    // R6: data line low outside word transmission
    p_sdo_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != ST_SHIFT) |-> !sdout);
    // R7: writes come only from the capture phase
    p_write_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_we |-> ($past(q.state) == ST_CAPTURE));
    // R8: each write is a single-cycle pulse
    p_we_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_we |=> !pix_we);
    // R9: done coincides with the last write of the line
    p_done_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> (pix_we && (pix_addr == PIX_LAST)));
endmodule

// File: tb/sim_line_sensor_ctrl.sv
module sim_line_sensor_ctrl;
    localparam int HALF  = 2;
    localparam int BOOT  = 20;
    localparam int DEPTH = 8;
    localparam int NPIX  = 16;
    localparam int LINES = 3;
    localparam int IAW   = $clog2(DEPTH);
    localparam int PAW   = $clog2(NPIX);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sdin = 1'b0;
    logic sclk, sdout, pix_we, line_done;
    logic [IAW-1:0] instr_addr;
    logic [15:0]    instr_word;
    logic [PAW-1:0] pix_addr;
    logic [7:0]     pix_data;

    logic [15:0] rom [DEPTH];
    assign instr_word = rom[instr_addr];

    line_sensor_ctrl #(
        .SCK_HALF(HALF), .STARTUP_CYCLES(BOOT),
        .INSTR_DEPTH(DEPTH), .PIXELS_PER_LINE(NPIX)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdout(sdout), .sdin(sdin),
        .instr_addr(instr_addr), .instr_word(instr_word),
        .pix_addr(pix_addr), .pix_data(pix_data), .pix_we(pix_we),
        .line_done(line_done)
    );

    always #2 clk = ~clk;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;
    bit finished = 0;

    logic [15:0] exp_words [DEPTH];
    logic [7:0]  exp_pix [LINES][NPIX];
    int  n_exp, n_got, nbits, line_idx, pix_seen, last_edge;
    bit  tx_phase, capture_phase;
    logic [15:0] acc;
    logic prev_sck = 1'b0;
    logic prev_sdo = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rand_word();
        logic [15:0] w;
        w = 16'($urandom);
        if (w == 16'hFFFF) w = 16'h7FFE;
        return w;
    endfunction

    function automatic bit expect_done(input int idx);
        return idx == NPIX - 1;
    endfunction

    always @(posedge clk) cyc++;

    // serial-side monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (sdout != prev_sdo)
                check(sclk == 1'b0, "R3 sdout changed while sclk high", sclk, 0);
            if (sclk != prev_sck) begin
                if (capture_phase)
                    check(cyc - last_edge == HALF, "R2 sclk half period", cyc - last_edge, HALF);
                last_edge = cyc;
            end
            if (!prev_sck && sclk) begin
                if (tx_phase) begin
                    acc = {acc[14:0], sdout};
                    nbits++;
                    if (nbits == 16) begin
                        check(acc == exp_words[n_got], "R4 script word", acc, exp_words[n_got]);
                        n_got++;
                        nbits = 0;
                        if (n_got == n_exp) tx_phase = 0;
                    end
                end else begin
                    check(sdout == 1'b0, "R6 sdout low after script", sdout, 0);
                end
            end
        end
        prev_sck = sclk;
        prev_sdo = sdout;
    end

    // pixel buffer monitor
    always @(negedge clk) begin
        if (rst_n && pix_we) begin
            check(capture_phase, "R7 write before start bit", 1, 0);
            if (line_idx < LINES) begin
                check(pix_addr == PAW'(pix_seen), "R8 pixel address", pix_addr, pix_seen);
                check(pix_data == exp_pix[line_idx][pix_seen], "R8 pixel data",
                      pix_data, exp_pix[line_idx][pix_seen]);
                check(line_done == expect_done(pix_seen), "R9 done with final write",
                      line_done, expect_done(pix_seen));
            end else begin
                check(0, "R9 extra write", pix_addr, 0);
            end
            pix_seen++;
            if (pix_seen == NPIX) begin
                pix_seen = 0;
                line_idx++;
            end
        end else if (rst_n && line_done) begin
            check(0, "R9 done without write", 1, 0);
        end
    end

    task automatic wait_fall();
        logic p;
        p = sclk;
        forever begin
            @(negedge clk);
            if (p && !sclk) break;
            p = sclk;
        end
    endtask

    task automatic send_line(input int l, input int gap);
        for (int g = 0; g < gap; g++) begin
            wait_fall();
            sdin = 1'b0;
        end
        wait_fall();
        sdin = 1'b1;
        capture_phase = 1;
        for (int p = 0; p < NPIX; p++) begin
            for (int b = 7; b >= 0; b--) begin
                wait_fall();
                sdin = exp_pix[l][p][b];
            end
        end
    endtask

    task automatic run_scenario(input int kind);
        int low_run;
        int guard;
        // script image
        for (int i = 0; i < DEPTH; i++) rom[i] = rand_word();
        if (kind == 0) rom[5] = 16'hFFFF;
        if (kind == 1) rom[0] = 16'hFFFF;
        n_exp = (kind == 0) ? 5 : (kind == 1) ? 0 : DEPTH;
        for (int i = 0; i < DEPTH; i++) exp_words[i] = rom[i];
        // pixel image
        for (int l = 0; l < LINES; l++)
            for (int p = 0; p < NPIX; p++)
                exp_pix[l][p] = 8'($urandom);
        if (kind == 1)
            for (int p = 0; p < NPIX; p++)
                exp_pix[0][p] = (p % 4 == 0) ? 8'hFF : (p % 4 == 1) ? 8'h00 :
                                (p % 4 == 2) ? 8'h80 : 8'h01;
        // reset
        @(negedge clk);
        rst_n = 1'b0;
        sdin = 1'b0;
        tx_phase = (n_exp > 0);
        capture_phase = 0;
        n_got = 0; nbits = 0; line_idx = 0; pix_seen = 0; acc = '0; last_edge = 0;
        repeat (3) @(negedge clk);
        check(sclk == 0 && sdout == 0, "R1 serial lines low in reset", {sclk, sdout}, 0);
        check(pix_we == 0 && line_done == 0, "R1 write port idle in reset", {pix_we, line_done}, 0);
        check(instr_addr == 0, "R1 instruction address in reset", instr_addr, 0);
        rst_n = 1'b1;
        low_run = 0;
        while (!sclk && low_run < 10 * BOOT) begin
            @(negedge clk);
            if (!sclk) low_run++;
        end
        check(low_run >= BOOT && low_run <= BOOT + HALF + 3, "R1 startup hold", low_run, BOOT);
        // sensor chatter during script is to be ignored
        while (n_got < n_exp) begin
            wait_fall();
            sdin = (n_got < n_exp) ? 1'($urandom) : 1'b0;
        end
        sdin = 1'b0;
        send_line(0, 1 + $urandom_range(0, 2));
        send_line(1, 0);
        send_line(2, $urandom_range(0, 2));
        wait_fall();
        sdin = 1'b0;
        guard = 0;
        while (line_idx < LINES && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        repeat (4 * HALF) @(negedge clk);
        check(line_idx == LINES && pix_seen == 0, "R9 all lines completed", line_idx, LINES);
        check(n_got == n_exp, "R5 script length", n_got, n_exp);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        run_scenario(0);
        run_scenario(1);
        run_scenario(2);
        run_scenario(0);
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        summary();
    end
endmodule